// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block sits between the data side of an 8-bit processor and an asynchronous SRAM reached over a narrow multiplexed bus. The low address byte and the data byte share one set of eight pins. An address-latch-enable strobe marks the short window in which those pins carry the address, so that an external transparent latch can hold it. The upper address bits leave on a separate bus, and a 3-bit code sets how many of those bits are driven. Active-low read and write strobes frame the data transfer.

Every request runs the same fixed sequence: an address phase, a strobe phase and a release phase. On external accesses the strobe phase can be stretched by zero to three wait states. The access is classified by comparing the address with the top of internal SRAM. Internal accesses still show address, data and latch-enable activity on the pins, but the strobes stay inactive. While the interface is disabled it gives up every pin to normal port control, and the address range above internal SRAM reads as zero.

Top module: `xmem_bus_ctrl`

## Requirements
- R1: After reset the block is idle: `ale` is 0, `rd_n` and `wr_n` are 1, `ad_oe` is 0 and `cpu_rdy` is 0.
- R2: An access whose address is strictly greater than `SRAM_TOP` (default 0x10FF) is external. Any other address is internal, and an internal access never drives `rd_n` or `wr_n` low.
- R3: In the first cycle after a request is accepted, with the interface enabled, `ale` is 1, `ad_oe` is 1 and `ad_out` equals address bits 7:0. On every driven high pin, `ahi_out` equals the matching bit of address bits 15:8.
- R4: `ale` is high for exactly one cycle per access, and it stays low through the strobe and release phases.
- R5: On a write, `ad_out` carries the write data with `ad_oe` high from the cycle after the address phase through the release cycle. On an external write, `wr_n` is low for 1+W cycles, where W is the wait count.
- R6: On a read, `ad_oe` is 0 after the address phase. On an external read, `rd_n` is low for 1+W cycles, and `cpu_rdata` shows the `ad_in` value present on the last of those cycles.
- R7: `cfg_wait` (0 to 3) is sampled when the request is accepted and applies only to external accesses. Internal and unmapped accesses always have a one-cycle strobe phase.
- R8: `cpu_rdy` is a one-cycle pulse in the cycle the strobe is released. It arrives 3+W cycles after acceptance for external accesses and 3 cycles after acceptance otherwise.
- R9: `cfg_hiw` code c selects the number of driven high address bits: 8-c for c from 0 to 6, and none for c = 7. The driven bits are the lowest ones, starting at address bit 8. `ahi_oe` shows this mask whenever the interface is enabled.
- R10: With `cfg_en` at 0, `pin_ovr`, `ale`, `ad_oe` and `ahi_oe` are all 0 and both strobes stay high. Accesses still complete with `cpu_rdy` after 3 cycles.
- R11: A read that is internal, or that is made while the interface is disabled, returns `cpu_rdata` = 0x00.
- R12: A request raised while an access is in progress is ignored. No second address phase follows the release cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_en | input | 1 | Interface enable |
| cfg_wait | input | 2 | Wait states for external accesses |
| cfg_hiw | input | 3 | High-address width code |
| cpu_req | input | 1 | Access request, accepted while idle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | Access address |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, valid with `cpu_rdy` |
| cpu_rdy | output | 1 | Access complete |
| pin_ovr | output | 1 | Interface owns its pins |
| ad_out | output | 8 | Multiplexed address/data out |
| ad_in | input | 8 | Multiplexed data in |
| ad_oe | output | 1 | Drive enable for `ad_out` |
| ahi_out | output | 8 | High address bits 15:8 |
| ahi_oe | output | 8 | Per-bit drive enable of the high address bus |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |

## Verification
If the accepting edge is called cycle 0, the address phase is due in cycle 1 and the strobe phase in cycles 2 to 2+W. The release cycle with `cpu_rdy` and valid read data is cycle 3+W, with W forced to 0 for internal or disabled accesses. The bench works out W from the address, the enable and the wait setting. It then samples every pin at the falling edge of each numbered cycle and checks one more cycle to confirm that nothing restarts. In each strobe cycle it changes `ad_in` to a value tied to the cycle number, so the returned data shows which cycle was sampled.

// File: rtl/xmem_pkg.sv
// Shared types for the multiplexed external memory bus controller.
// Assumes a single clock domain and synchronous active-low reset.
package xmem_pkg;

    // Access phases, in the order they are visited.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_STRB = 2'd2,
        PH_REL  = 2'd3
    } xm_phase_t;

endpackage

// File: rtl/xmem_region.sv
// Classifies an address as external (above the internal SRAM top) or internal.
// Assumes SRAM_TOP is the last internal address.
module xmem_region #(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] SRAM_TOP = 16'h10FF
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              is_ext
);

    // Strict comparison: the top address itself is internal.
    always_comb is_ext = (addr > SRAM_TOP);

endmodule

// File: rtl/xmem_hi_mask.sv
// Turns the width code into a per-bit drive mask for the high address bus.
// Code all-ones drives nothing; code c otherwise drives HI_W-c low-order bits.
// Assumes HI_W >= 2**HCODE_W - 1 so that every code maps to a valid width.
module xmem_hi_mask #(
    parameter int HI_W    = 8,
    parameter int HCODE_W = 3
) (
    input  logic               en,
    input  logic [HCODE_W-1:0] code,
    output logic [HI_W-1:0]    mask
);

    int width;

    // Number of high bits the code asks for.
    always_comb width = (code == {HCODE_W{1'b1}}) ? 0 : (HI_W - int'(code));

    for (genvar i = 0; i < HI_W; i++) begin : g_bit
        // Bit i is driven when the interface is on and i lies inside the width.
        assign mask[i] = en && (i < width);
    end

endmodule

// File: rtl/xmem_seq.sv
// Phase sequencer: idle -> address -> strobe (1+W cycles) -> release -> idle.
// Takes a request only while idle; the wait count is loaded on acceptance.
module xmem_seq
    import xmem_pkg::*;
#(
    parameter int WAIT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [WAIT_W-1:0] wait_ld,
    output xm_phase_t         phase,
    output logic              accept,
    output logic              samp
);

    logic [WAIT_W-1:0] cnt_q;

    // Request is taken only when no access is in flight.
    always_comb accept = (phase == PH_IDLE) && req;
    // Last strobe cycle: the read data is captured on the edge that ends it.
    always_comb samp = (phase == PH_STRB) && (cnt_q == '0);

    // Phase register and wait-state down counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt_q <= '0;
        end else begin
            case (phase)
                PH_IDLE: if (req) begin
                    phase <= PH_ADDR;
                    cnt_q <= wait_ld;
                end
                PH_ADDR: phase <= PH_STRB;
                PH_STRB: if (cnt_q == '0) phase <= PH_REL;
                         else cnt_q <= cnt_q - 1'b1;
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/xmem_bus_ctrl.sv
// Top of the multiplexed external memory bus controller.
// Latches the request, classifies it, runs the phase sequencer and drives the
// shared address/data pins, high address bus, latch enable and strobes.
// Assumes one request is outstanding at a time; the CPU waits for cpu_rdy.
module xmem_bus_ctrl
    import xmem_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter int                LO_W     = 8,
    parameter int                WAIT_W   = 2,
    parameter int                HCODE_W  = 3,
    parameter logic [ADDR_W-1:0] SRAM_TOP = 16'h10FF,
    localparam int               HI_W     = ADDR_W - LO_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_en,
    input  logic [WAIT_W-1:0]  cfg_wait,
    input  logic [HCODE_W-1:0] cfg_hiw,
    input  logic               cpu_req,
    input  logic               cpu_we,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic [LO_W-1:0]    cpu_wdata,
    output logic [LO_W-1:0]    cpu_rdata,
    output logic               cpu_rdy,
    output logic               pin_ovr,
    output logic [LO_W-1:0]    ad_out,
    input  logic [LO_W-1:0]    ad_in,
    output logic               ad_oe,
    output logic [HI_W-1:0]    ahi_out,
    output logic [HI_W-1:0]    ahi_oe,
    output logic               ale,
    output logic               rd_n,
    output logic               wr_n
);

    xm_phase_t         phase;
    logic              accept, samp, is_ext;
    logic [WAIT_W-1:0] wait_ld;
    logic [ADDR_W-1:0] addr_q;
    logic [LO_W-1:0]   wdata_q, rdata_q;
    logic              we_q, ext_q, strb_ph, data_ph;

    xmem_region #(.ADDR_W(ADDR_W), .SRAM_TOP(SRAM_TOP)) region_i (
        .addr   (cpu_addr),
        .is_ext (is_ext)
    );

    // Wait states only stretch accesses that really leave the chip.
    always_comb wait_ld = (is_ext && cfg_en) ? cfg_wait : '0;

    xmem_seq #(.WAIT_W(WAIT_W)) seq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (cpu_req),
        .wait_ld (wait_ld),
        .phase   (phase),
        .accept  (accept),
        .samp    (samp)
    );

    xmem_hi_mask #(.HI_W(HI_W), .HCODE_W(HCODE_W)) hmask_i (
        .en   (cfg_en),
        .code (cfg_hiw),
        .mask (ahi_oe)
    );

    // Capture the request attributes when it is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            we_q    <= 1'b0;
            ext_q   <= 1'b0;
        end else if (accept) begin
            addr_q  <= cpu_addr;
            wdata_q <= cpu_wdata;
            we_q    <= cpu_we;
            ext_q   <= is_ext && cfg_en;
        end
    end

    // Read data register: pin value for external reads, zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)               rdata_q <= '0;
        else if (samp && !we_q)   rdata_q <= ext_q ? ad_in : '0;
    end

    // Phase decodes used by the pin drivers.
    always_comb strb_ph = (phase == PH_STRB);
    always_comb data_ph = (phase == PH_STRB) || (phase == PH_REL);

    // Pin drivers; everything is gated by the enable so pins return to ports.
    always_comb begin
        pin_ovr   = cfg_en;
        ale       = cfg_en && (phase == PH_ADDR);
        ad_out    = (phase == PH_ADDR) ? addr_q[LO_W-1:0] : wdata_q;
        ad_oe     = cfg_en && ((phase == PH_ADDR) || (data_ph && we_q));
        ahi_out   = addr_q[ADDR_W-1:LO_W];
        rd_n      = !(cfg_en && ext_q && !we_q && strb_ph);
        wr_n      = !(cfg_en && ext_q &&  we_q && strb_ph);
        cpu_rdy   = (phase == PH_REL);
        cpu_rdata = rdata_q;
    end

endmodule

// File: rtl/xmem_bus_ctrl_chk.sv
// Protocol checker for xmem_bus_ctrl, attached with bind. Port-level only.
module xmem_bus_ctrl_chk #(
    parameter int HI_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cfg_en,
    input logic            ale,
    input logic            rd_n,
    input logic            wr_n,
    input logic            ad_oe,
    input logic            cpu_rdy,
    input logic [HI_W-1:0] ahi_oe
);

    // R4
    ale_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    // R4
    ale_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (rd_n && wr_n));

    // R2
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    // R5
    write_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> ad_oe);

    // R6
    read_floats_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);

    // R8
    rdy_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rdy |=> !cpu_rdy);

    // R8
    rdy_at_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rd_n) || $rose(wr_n)) |-> cpu_rdy);

    // R10
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |-> (rd_n && wr_n && !ad_oe && !ale && (ahi_oe == '0)));

endmodule

bind xmem_bus_ctrl xmem_bus_ctrl_chk #(.HI_W(HI_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_en  (cfg_en),
    .ale     (ale),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .ad_oe   (ad_oe),
    .cpu_rdy (cpu_rdy),
    .ahi_oe  (ahi_oe)
);

// File: tb/xmem_bus_ctrl_tb_top.sv
// Sweep bench: enable x direction x wait count x boundary addresses, with a
// rotating high-width code; expected pin values computed per cycle.
module xmem_bus_ctrl_tb_top;

    localparam logic [15:0] TOP = 16'h10FF;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_en = 1'b0;
    logic [1:0] cfg_wait = '0;
    logic [2:0] cfg_hiw = '0;
    logic       cpu_req = 1'b0, cpu_we = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0] cpu_wdata = '0, ad_in = '0;
    logic [7:0] cpu_rdata, ad_out, ahi_out, ahi_oe;
    logic       cpu_rdy, pin_ovr, ad_oe, ale, rd_n, wr_n;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    xmem_bus_ctrl #(.SRAM_TOP(TOP)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_wait(cfg_wait),
        .cfg_hiw(cfg_hiw), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_rdy(cpu_rdy), .pin_ovr(pin_ovr), .ad_out(ad_out), .ad_in(ad_in),
        .ad_oe(ad_oe), .ahi_out(ahi_out), .ahi_oe(ahi_oe), .ale(ale),
        .rd_n(rd_n), .wr_n(wr_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic int mask_of(input int code, input bit en);
        int w = (code == 7) ? 0 : 8 - code;
        return en ? ((1 << w) - 1) : 0;
    endfunction

    task automatic access(input bit en, input bit we, input logic [15:0] a,
                          input logic [7:0] wd, input int w, input int hc);
        bit ext = en && (a > TOP);
        int ww = ext ? w : 0;
        int m = mask_of(hc, en);
        logic [7:0] base = a[7:0] ^ 8'h5A;
        cfg_en = en; cfg_wait = 2'(w); cfg_hiw = 3'(hc);
        cpu_we = we; cpu_addr = a; cpu_wdata = wd; cpu_req = 1'b1; ad_in = '0;
        @(posedge clk);
        for (int n = 1; n <= 4 + ww; n++) begin
            @(negedge clk);
            chk(int'(ahi_oe) == m, "R9 ahi_oe", ahi_oe, m);
            chk(pin_ovr == en, "R10 pin_ovr", pin_ovr, en);
            if (n == 1) begin
                // R3 address phase
                chk(ale == en, "R3 ale", ale, en);
                chk(ad_oe == en, "R3 ad_oe", ad_oe, en);
                if (en) chk(ad_out == a[7:0], "R3 ad_out", ad_out, a[7:0]);
                chk((int'(ahi_out) & m) == (int'(a[15:8]) & m), "R3 ahi_out",
                    int'(ahi_out) & m, int'(a[15:8]) & m);
                chk(rd_n && wr_n && !cpu_rdy, "R2 idle strobes in addr phase",
                    {rd_n, wr_n, cpu_rdy}, 3'b110);
                // R12: a request raised now must be ignored
                cpu_req = 1'b1; cpu_addr = ~a;
            end else if (n <= 2 + ww) begin
                cpu_req = 1'b0;
                chk(!ale, "R4 ale low in strobe phase", ale, 0);
                chk(rd_n == !(ext && !we), "R6 rd_n", rd_n, !(ext && !we));
                chk(wr_n == !(ext && we), "R5 wr_n", wr_n, !(ext && we));
                chk(ad_oe == (en && we), "R5 R6 ad_oe", ad_oe, en && we);
                if (en && we) chk(ad_out == wd, "R5 ad_out data", ad_out, wd);
                chk(!cpu_rdy, "R7 no early ready", cpu_rdy, 0);
                ad_in = base ^ 8'(n);
            end else if (n == 3 + ww) begin
                cpu_req = 1'b0;
                chk(cpu_rdy, "R8 ready at release", cpu_rdy, 1);
                chk(rd_n && wr_n && !ale, "R4 release pins",
                    {rd_n, wr_n, ale}, 3'b110);
                chk(ad_oe == (en && we), "R5 data held in release", ad_oe, en && we);
                if (en && we) chk(ad_out == wd, "R5 ad_out held", ad_out, wd);
                if (!we) begin
                    logic [7:0] ex = ext ? (base ^ 8'(2 + ww)) : 8'h00;
                    chk(cpu_rdata == ex, ext ? "R6 read data" : "R11 read zero",
                        cpu_rdata, ex);
                end
            end else begin
                chk(!cpu_rdy && !ale, "R12 no second access",
                    {cpu_rdy, ale}, 0);
            end
        end
    endtask

    initial begin
        logic [15:0] addrs [5];
        addrs[0] = 16'h0000; addrs[1] = TOP; addrs[2] = TOP + 16'd1;
        addrs[3] = 16'hFFFF; addrs[4] = 16'hA55C;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!ale && rd_n && wr_n && !ad_oe && !cpu_rdy, "R1 reset state",
            {ale, rd_n, wr_n, ad_oe, cpu_rdy}, 5'b01100);
        rst_n = 1'b1;
        cfg_en = 1'b1;
        @(negedge clk);
        chk(!ale && rd_n && wr_n && !ad_oe && !cpu_rdy, "R1 idle after reset",
            {ale, rd_n, wr_n, ad_oe, cpu_rdy}, 5'b01100);
        for (int c = 0; c < 8; c++) begin
            cfg_hiw = 3'(c);
            #1;
            chk(int'(ahi_oe) == mask_of(c, 1'b1), "R9 width code", ahi_oe, mask_of(c, 1'b1));
        end
        for (int e = 1; e >= 0; e--)
            for (int we = 0; we < 2; we++)
                for (int w = 0; w < 4; w++)
                    for (int i = 0; i < 5; i++) begin
                        @(negedge clk);
                        access(e[0], we[0], addrs[i], 8'(8'hC3 ^ (i * 17 + w)), w, (i + w) % 8);
                    end
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) chk(1'b0, "watchdog", cyc, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule